// File: doc/BRIEF.md
# Unified-Memory Two-Phase RISC Core

This block is a 32-bit processor core that runs a twelve-instruction integer instruction set. Instructions and data share one word-addressed memory of 2048 words. Program code occupies words 0 to 1023 and data occupies words 1024 to 2047. The core alternates between two phases. In the fetch phase it reads the word at the program counter into an instruction register. In the execute phase it does all of the following in one cycle: it reads registers, computes, makes at most one data access and writes back. Because of this, the single memory port never has two users in the same cycle.

The memory sits inside the block. A host fills it through a load stream before execution starts. The host sees the core's progress only on a small debug port, which carries the current program counter and a halt flag. The load stream is valid/ready with the following back-pressure rules:
- `load_ready` is high only while the core is held in reset or has halted.
- A word is written on each rising edge where `load_valid` and `load_ready` are both high.
- While the core runs, `load_ready` stays low. The host must hold `load_addr` and `load_data` until it sees `load_ready` high.

Top module: `spc_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter becomes 0, the halt flag clears and all 32 registers become zero. After release, execution starts with the word at address 0. Memory contents survive reset.
- R2: Field positions in the instruction word:
  - Opcode is bits [31:28].
  - The destination/first register field is [27:23].
  - The source register field is [22:18].
  - The second source field is [17:13].
  - The shift amount is [12:0].
  - The immediate is [17:0].
  - The jump target is [27:0].
  
  Opcode values: ADD 0, SUB 1, MULI 2, ADDI 3, BNE 4, ANDI 5, ORI 6, J 7, SLL 8, SRL 9, LW 10, SW 11, halt 12 to 15.
- R3: Every instruction takes exactly two cycles. When N instructions run before a halt opcode, `dbg_halted` is first seen high 2*(N+1) rising edges after reset release.
- R4: ADD writes the sum of the source and second source into the destination. SUB writes source minus second source.
- R5: ADDI and MULI use the immediate sign-extended from bit 17. MULI keeps the low 32 bits of the product.
- R6: ANDI and ORI use the immediate zero-extended.
- R7: SLL and SRL shift the source logically by the 13-bit shift amount. A shift of 32 or more yields zero.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: The address for LW and SW is the low 11 bits of the source register plus the sign-extended immediate. SW stores the destination-field register. Instruction fetch reads the same memory, so a store is visible to the next fetch.
- R10: BNE compares the destination-field register with the source register. When they differ, the next PC is PC+1 plus the sign-extended immediate. When they are equal, the next PC is PC+1. The offset may be negative.
- R11: J sets the PC to the upper 4 PC bits concatenated with the 28-bit target.
- R12: Opcodes 12 to 15 stop the core. `dbg_pc` then holds the address of the halting word, and the PC and halt flag stay frozen until reset.
- R13: `load_ready` is high exactly while `rst` is high or the core has halted. A word is written at `load_addr` when `load_valid` and `load_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Host offers a word to write |
| load_ready | output | 1 | Core accepts host writes (reset or halted) |
| load_addr | input | 11 | Word address of host write |
| load_data | input | 32 | Word to write |
| dbg_pc | output | 32 | Current program counter |
| dbg_halted | output | 1 | Core has executed a halt opcode |

## Verification
On every cycle, the embedded assertions check four things:
- The phase order is fetch followed by execute.
- The PC moves by exactly one after every non-control, non-halting instruction.
- A halted core keeps its PC and stays halted.
- Register 0 reads as zero and written results land in their destination register.

Arithmetic results, immediate extension, shift limits, memory addressing, branch and jump targets, and self-modifying stores are exposed only at the ports. The bench therefore runs programs that compare computed values against constants in registers and branch to a failure halt on a mismatch. The final halt address and the cycle count then show which path ran.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int ILEN  = 32;
  localparam int OPW   = 4;
  localparam int REGW  = 5;
  localparam int IMMW  = 18;
  localparam int SHW   = 13;
  localparam int JAW   = 28;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_MULI = 4'd2,  OP_ADDI = 4'd3,
    OP_BNE  = 4'd4,  OP_ANDI = 4'd5,  OP_ORI  = 4'd6,  OP_J    = 4'd7,
    OP_SLL  = 4'd8,  OP_SRL  = 4'd9,  OP_LW   = 4'd10, OP_SW   = 4'd11,
    OP_HLT0 = 4'd12, OP_HLT1 = 4'd13, OP_HLT2 = 4'd14, OP_HLT3 = 4'd15
  } opc_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} cstate_e;

  typedef struct packed {
    opc_e            op;
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rs;
    logic [REGW-1:0] rt;
    logic [SHW-1:0]  sh;
    logic [IMMW-1:0] imm;
    logic [JAW-1:0]  jtgt;
  } dec_t;

  // All formats overlay one word; each consumer picks the fields it needs.
  function automatic dec_t decode(logic [ILEN-1:0] w);
    dec_t d;
    d.op   = opc_e'(w[31:28]);
    d.rd   = w[27:23];
    d.rs   = w[22:18];
    d.rt   = w[17:13];
    d.sh   = w[12:0];
    d.imm  = w[17:0];
    d.jtgt = w[27:0];
    return d;
  endfunction
endpackage

// File: rtl/spc_regfile.sv
module spc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   rsel_a,
  output logic [XLEN-1:0] rval_a,
  input  logic [RW-1:0]   rsel_b,
  output logic [XLEN-1:0] rval_b,
  input  logic            wen,
  input  logic [RW-1:0]   wsel,
  input  logic [XLEN-1:0] wval
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wen && wsel != '0) begin
      regs[wsel] <= wval;
    end
  end

  assign rval_a = (rsel_a == '0) ? '0 : regs[rsel_a];
  assign rval_b = (rsel_b == '0) ? '0 : regs[rsel_b];

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_b == '0) |-> (rval_b == '0));

  // R4
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wen && wsel != '0) |=> (regs[$past(wsel)] == $past(wval)));
endmodule

// File: rtl/spc_alu.sv
module spc_alu
  import spc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  opc_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IMMW-1:0] imm,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] imm_s, imm_z;

  assign imm_s = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign imm_z = {{(XLEN-IMMW){1'b0}}, imm};

  always_comb begin
    unique case (op)
      OP_ADD:                 y = a + b;
      OP_SUB:                 y = a - b;
      OP_MULI:                y = a * imm_s;
      OP_ADDI, OP_LW, OP_SW:  y = a + imm_s;
      OP_ANDI:                y = a & imm_z;
      OP_ORI:                 y = a | imm_z;
      OP_SLL:                 y = a << sh;
      OP_SRL:                 y = a >> sh;
      default:                y = '0;
    endcase
  end
endmodule

// File: rtl/spc_umem.sv
module spc_umem #(
  parameter int WORDS = 2048,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            wen,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] rval
);
  logic [XLEN-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wen) cells[addr] <= wval;
  end

  assign rval = cells[addr];
endmodule

// File: rtl/spc_core.sv
module spc_core
  import spc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 2048,
  parameter int NREGS     = 32,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_valid,
  output logic            load_ready,
  input  logic [AW-1:0]   load_addr,
  input  logic [XLEN-1:0] load_data,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_halted
);
  cstate_e         st;
  logic [XLEN-1:0] pc, ir;
  dec_t            d;
  logic            is_halt, is_ctl, writes_rd;
  logic [XLEN-1:0] rv_a, rv_b, alu_y, mem_rd, imm_s, pc_nxt;
  logic [REGW-1:0] sel_b;
  logic            ld_fire, st_fire, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [XLEN-1:0] mem_wd;

  assign d       = decode(ir);
  assign is_halt = (d.op[3:2] == 2'b11);
  assign is_ctl  = (d.op == OP_BNE) || (d.op == OP_J);
  assign imm_s   = {{(XLEN-IMMW){d.imm[IMMW-1]}}, d.imm};

  always_comb begin
    unique case (d.op)
      OP_ADD, OP_SUB, OP_MULI, OP_ADDI, OP_ANDI, OP_ORI,
      OP_SLL, OP_SRL, OP_LW: writes_rd = 1'b1;
      default:               writes_rd = 1'b0;
    endcase
  end

  // Port B reads the destination field when it is a source (compare, store data).
  assign sel_b = (d.op == OP_BNE || d.op == OP_SW) ? d.rd : d.rt;

  spc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) rf_i (
    .clk    (clk),
    .rst    (rst),
    .rsel_a (d.rs),
    .rval_a (rv_a),
    .rsel_b (sel_b),
    .rval_b (rv_b),
    .wen    ((st == ST_EXEC) && !rst && writes_rd),
    .wsel   (d.rd),
    .wval   ((d.op == OP_LW) ? mem_rd : alu_y)
  );

  spc_alu #(.XLEN(XLEN)) alu_i (
    .op  (d.op),
    .a   (rv_a),
    .b   (rv_b),
    .imm (d.imm),
    .sh  (d.sh),
    .y   (alu_y)
  );

  // Single memory port: host owns it in reset/halt, else the phase picks.
  assign load_ready = rst || (st == ST_HALT);
  assign ld_fire    = load_valid && load_ready;
  assign st_fire    = (st == ST_EXEC) && !rst && (d.op == OP_SW);
  assign mem_we     = ld_fire || st_fire;
  assign mem_wd     = load_ready ? load_data : rv_b;
  assign mem_addr   = load_ready         ? load_addr :
                      (st == ST_FETCH)   ? pc[AW-1:0] : alu_y[AW-1:0];

  spc_umem #(.WORDS(MEM_WORDS), .XLEN(XLEN)) mem_i (
    .clk  (clk),
    .wen  (mem_we),
    .addr (mem_addr),
    .wval (mem_wd),
    .rval (mem_rd)
  );

  always_comb begin
    unique case (d.op)
      OP_BNE:  pc_nxt = (rv_a != rv_b) ? pc + 1 + imm_s : pc + 1;
      OP_J:    pc_nxt = {pc[XLEN-1:JAW], d.jtgt};
      default: pc_nxt = pc + 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FETCH;
      pc <= '0;
      ir <= '0;
    end else begin
      unique case (st)
        ST_FETCH: begin
          ir <= mem_rd;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_halt) begin
            st <= ST_HALT;
          end else begin
            pc <= pc_nxt;
            st <= ST_FETCH;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign dbg_pc     = pc;
  assign dbg_halted = (st == ST_HALT);

  // R3
  fetch_exec_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH) |=> (st == ST_EXEC));

  // R3
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && !is_halt && !is_ctl) |=> (pc == $past(pc) + 1));

  // R12
  halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT) |=> (st == ST_HALT && $stable(pc)));

  // R13
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    st_fire |-> !load_ready);
endmodule

// File: tb/spc_core_tb_top.sv
module spc_core_tb_top;
  localparam int AW = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic        load_ready;
  logic [31:0] dbg_pc;
  logic        dbg_halted;

  always #5 clk = ~clk;

  spc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .load_ready (load_ready),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .dbg_pc     (dbg_pc),
    .dbg_halted (dbg_halted)
  );

  typedef struct {
    string tag;
    int    exp_pc;
    int    exp_cyc;
  } exp_t;

  int          n_chk = 0;
  int          n_fail = 0;
  exp_t        sb[$];
  logic [31:0] prog[$];
  int          xa[$];
  logic [31:0] xd[$];
  logic        mon_arm = 1'b0;
  localparam int FAIL_AT = 1000;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fr(int op, int a, int b, int c, int sh);
    return {4'(op), 5'(a), 5'(b), 5'(c), 13'(sh)};
  endfunction
  function automatic logic [31:0] fi(int op, int a, int b, int imm);
    return {4'(op), 5'(a), 5'(b), 18'(imm)};
  endfunction
  function automatic logic [31:0] fj(int op, int tgt);
    return {4'(op), 28'(tgt)};
  endfunction

  task automatic emit(logic [31:0] w);
    prog.push_back(w);
  endtask

  // Build a 32-bit constant: ADDI upper 14 bits, SLL 18, ORI lower 18.
  task automatic ldc(int rd, logic [31:0] v);
    emit(fi(3, rd, 0, int'({4'b0, v[31:18]})));
    emit(fr(8, rd, rd, 0, 18));
    emit(fi(6, rd, rd, int'(v[17:0])));
  endtask

  // Branch to the failure halt when the two registers differ.
  task automatic chk_eq(int x, int y);
    int here = prog.size();
    emit(fi(4, x, y, FAIL_AT - (here + 1)));
  endtask

  task automatic load_word(int addr, logic [31:0] w);
    @(negedge clk);
    load_valid = 1'b1;
    load_addr  = AW'(addr);
    load_data  = w;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic run_prog(string tag, int exp_pc, int exp_n, bit probe_ready);
    exp_t e;
    rst = 1'b1;
    @(negedge clk);
    foreach (prog[i]) load_word(i, prog[i]);
    load_word(FAIL_AT, fj(15, 0));
    foreach (xa[i]) load_word(xa[i], xd[i]);
    e.tag = tag; e.exp_pc = exp_pc; e.exp_cyc = 2 * (exp_n + 1);
    sb.push_back(e);
    prog.delete(); xa.delete(); xd.delete();
    @(negedge clk);
    rst = 1'b0;
    mon_arm = 1'b1;
    if (probe_ready) begin
      @(posedge clk); #1;
      check("R13 ready low while running", 32'(load_ready), 32'd0);
    end
    wait (mon_arm == 1'b0);
  endtask

  // Monitor: time the run, pop the expected item, compare.
  initial begin
    int   cyc;
    exp_t e;
    forever begin
      wait (mon_arm == 1'b1);
      cyc = 0;
      while (cyc < 4000) begin
        @(posedge clk); #1;
        cyc++;
        if (dbg_halted) break;
      end
      e = sb.pop_front();
      check({e.tag, " halt flag"}, 32'(dbg_halted), 32'd1);
      check({e.tag, " halt pc"}, dbg_pc, 32'(e.exp_pc));
      check({"R3 cycles ", e.tag}, 32'(cyc), 32'(e.exp_cyc));
      mon_arm = 1'b0;
    end
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int h;

    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 pc in reset", dbg_pc, 32'd0);
    check("R1 halt in reset", 32'(dbg_halted), 32'd0);
    check("R13 ready in reset", 32'(load_ready), 32'd1);

    // P1: R2 encodings, R4 add/sub, R5 negative ADDI, R8 zero register
    emit(fi(3, 1, 0, 5));
    emit(fi(3, 2, 0, 7));
    emit(fr(0, 3, 1, 2, 0));
    ldc(4, 32'd5 + 32'd7);
    chk_eq(3, 4);
    emit(fr(1, 5, 1, 2, 0));
    ldc(6, 32'd5 - 32'd7);
    chk_eq(5, 6);
    emit(fi(3, 8, 0, -3));
    ldc(9, 32'hFFFF_FFFD);
    chk_eq(8, 9);
    emit(fi(3, 0, 0, 9));
    emit(fr(0, 0, 1, 2, 0));
    chk_eq(0, 7);
    h = prog.size();
    emit(fj(12, 0));
    run_prog("R2/R4/R5/R8", h, h, 1'b1);

    // P2: R1 registers cleared by reset, R5 MULI, R6 zero-extended logic ops
    chk_eq(9, 0);
    v = 32'h0001_2345;
    ldc(1, v);
    emit(fi(2, 2, 1, -3));
    ldc(3, v * 32'hFFFF_FFFD);
    chk_eq(2, 3);
    w = 32'hFFFF_0F0F;
    ldc(5, w);
    emit(fi(5, 4, 5, 32'h2F0F0));
    ldc(6, w & 32'h0002_F0F0);
    chk_eq(4, 6);
    emit(fi(6, 7, 5, 32'h30001));
    ldc(8, w | 32'h0003_0001);
    chk_eq(7, 8);
    h = prog.size();
    emit(fj(12, 0));
    run_prog("R1/R5/R6", h, h, 1'b0);

    // P3: R7 shifts including an amount of 32 or more
    v = 32'h8000_0001;
    ldc(1, v);
    emit(fr(8, 2, 1, 0, 4));
    ldc(3, v << 4);
    chk_eq(2, 3);
    emit(fr(9, 4, 1, 0, 31));
    emit(fi(3, 5, 0, 1));
    chk_eq(4, 5);
    emit(fr(9, 6, 1, 0, 5));
    ldc(7, v >> 5);
    chk_eq(6, 7);
    emit(fr(8, 8, 1, 0, 40));
    chk_eq(8, 0);
    h = prog.size();
    emit(fj(14, 0));
    run_prog("R7", h, h, 1'b0);

    // P4: R9 loads, stores, negative offset, preloaded data, self-modifying store
    v = 32'hCAFE_1234;
    ldc(1, v);
    emit(fi(3, 2, 0, 1030));
    emit(fi(11, 1, 2, 5));
    emit(fi(10, 3, 2, 5));
    chk_eq(1, 3);
    emit(fi(3, 4, 0, 1040));
    emit(fi(10, 5, 4, -5));
    chk_eq(5, 1);
    xa.push_back(1500); xd.push_back(32'h0BAD_F00D);
    emit(fi(10, 6, 0, 1500));
    ldc(7, 32'h0BAD_F00D);
    chk_eq(6, 7);
    ldc(8, fj(14, 0));
    h = prog.size();
    emit(fi(11, 8, 0, h + 1));
    emit(fj(7, FAIL_AT));
    run_prog("R9", h + 1, h + 1, 1'b0);

    // P5: R10 backward branch loop, R11 jump
    emit(fi(3, 1, 0, 3));
    emit(fi(3, 1, 1, -1));
    emit(fi(4, 1, 0, -2));
    emit(fj(7, 10));
    for (int k = 4; k < 10; k++) emit(fj(12, 0));
    chk_eq(1, 0);
    emit(fj(13, 0));
    run_prog("R10/R11", 11, 9, 1'b0);

    // P6: R12 halt at address 0, then frozen
    emit(fj(15, 0));
    run_prog("R12", 0, 0, 1'b0);
    repeat (10) @(negedge clk);
    check("R12 pc frozen", dbg_pc, 32'd0);
    check("R12 halt held", 32'(dbg_halted), 32'd1);
    check("R13 ready when halted", 32'(load_ready), 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule